// File: doc/BRIEF.md
# Snapshot-Loaded Serial Output Shifter

This block holds a parallel byte in a storage register and sends it out one bit at a time through a shift register. The storage register takes a new byte only when its capture strobe is high. The shift register then takes the stored byte as a whole, or it takes one bit at a time from a serial input, depending on the operating mode. Because the byte is held first, software can capture the next byte while the previous one is still leaving. Loads copy that held snapshot, not the live input pins.

Only the last stage of the shift chain reaches the outside, as one serial data bit paired with an enable bit. At the chip edge this pair becomes a tri-state driver, so several such blocks can share one line, for example the data-in line of an SPI-style controller. Both strobes are synchronous enables in a single clock domain.

The mode input picks one of two named operations for each shift strobe:
- **OP_SHIFT** (`load_mode`=0): the chain moves one stage toward the output and takes `ser_in` at the input end.
- **OP_LOAD** (`load_mode`=1): the chain copies the held byte.

There is no other state and no transition between modes. The operation is chosen again on every strobe.

Top module: `lsr_snapshot_shifter`

## Requirements
- R1: While `rst` is high at a clock edge, the storage register and the shift chain both become zero. After reset, with `oe_n`=0, every bit shifted out is 0 until new data arrives.
- R2: At a clock edge where `cap_en`=1, `par_in` is copied into the storage register. When `cap_en`=0, changes on `par_in` have no effect on any later load.
- R3: At a clock edge where `shift_en`=1 and `load_mode`=1, the shift chain takes the stored byte. The chain is indexed with bit 7 at the output end and bit 0 at the input end.
- R4: At a clock edge where `shift_en`=1 and `load_mode`=0, every stage moves one place toward bit 7, and `ser_in` enters bit 0.
- R5: At a clock edge where `shift_en`=0, the shift chain keeps its value.
- R6: `oe_n` is active low. While `oe_n`=1, `ser_out_en`=0 and `ser_out`=0. While `oe_n`=0, `ser_out_en`=1 and `ser_out` equals chain bit 7. Both follow `oe_n` in the same cycle, with no register in between.
- R7: When a capture and a load fall on the same edge, the chain takes the byte that was stored before that edge. The newly captured byte is available to the next load.
- R8: A capture taken while a byte is shifting out does not change the bits still in the chain.
- R9: After a load, the byte leaves most significant bit first. Bit 7 is visible at once, and each later shift exposes the next lower bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cap_en | input | 1 | Capture strobe for the storage register |
| par_in | input | 8 | Parallel data byte |
| shift_en | input | 1 | Shift or load strobe for the chain |
| load_mode | input | 1 | 1 selects OP_LOAD, 0 selects OP_SHIFT |
| ser_in | input | 1 | Serial data entering chain bit 0 |
| oe_n | input | 1 | Output enable, active low |
| ser_out | output | 1 | Serial data from chain bit 7, 0 when disabled |
| ser_out_en | output | 1 | Drive enable for the shared line |

## Verification
A capture or a chain update shows up one clock edge after the strobe that caused it. Chain bit 7 then reaches `ser_out` with no further delay, and the enable pair responds to `oe_n` within the same cycle. The bench changes its inputs on the falling edge and reads the outputs on the next falling edge, so every read sees exactly one rising edge after its stimulus. The `oe_n` checks are read before any edge passes.

// File: rtl/lsr_pkg.sv
package lsr_pkg;
    typedef enum logic [0:0] {
        OP_SHIFT = 1'b0,
        OP_LOAD  = 1'b1
    } op_e;
endpackage

// File: rtl/lsr_hold_reg.sv
module lsr_hold_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cap_en,
    input  logic [WIDTH-1:0] par_in,
    output logic [WIDTH-1:0] held
);
    always_ff @(posedge clk) begin
        if (rst)
            held <= '0;
        else if (cap_en)
            held <= par_in;
    end

    AST_HOLD_RESET: assert property (@(posedge clk) rst |=> held == '0); // R1
    AST_HOLD_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        cap_en |=> held == $past(par_in)); // R2
    AST_HOLD_KEEP: assert property (@(posedge clk) disable iff (rst)
        !cap_en |=> $stable(held)); // R2
endmodule

// File: rtl/lsr_shift_chain.sv
module lsr_shift_chain
    import lsr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             shift_en,
    input  op_e              op,
    input  logic             ser_in,
    input  logic [WIDTH-1:0] load_val,
    output logic [WIDTH-1:0] chain
);
    localparam int TOP = WIDTH - 1;

    logic [WIDTH-1:0] chain_next;

    always_comb begin
        chain_next = chain;
        unique case (op)
            OP_SHIFT: chain_next = {chain[TOP-1:0], ser_in};
            OP_LOAD:  chain_next = load_val;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            chain <= '0;
        else if (shift_en)
            chain <= chain_next;
    end

    AST_CHAIN_RESET: assert property (@(posedge clk) rst |=> chain == '0); // R1
    AST_CHAIN_LOAD: assert property (@(posedge clk) disable iff (rst)
        (shift_en && op == OP_LOAD) |=> chain == $past(load_val)); // R3
    AST_CHAIN_SHIFT: assert property (@(posedge clk) disable iff (rst)
        (shift_en && op == OP_SHIFT) |=>
        (chain[0] == $past(ser_in) && chain[TOP:1] == $past(chain[TOP-1:0]))); // R4
    AST_CHAIN_HOLD: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> $stable(chain)); // R5
endmodule

// File: rtl/lsr_out_stage.sv
module lsr_out_stage (
    input  logic clk,
    input  logic rst,
    input  logic tail,
    input  logic oe_n,
    output logic ser_out,
    output logic ser_out_en
);
    always_comb begin
        ser_out_en = ~oe_n;
        ser_out    = tail & ~oe_n;
    end

    AST_OUT_OFF: assert property (@(posedge clk) disable iff (rst)
        oe_n |-> (!ser_out_en && !ser_out)); // R6
    AST_OUT_ON: assert property (@(posedge clk) disable iff (rst)
        !oe_n |-> (ser_out_en && ser_out == tail)); // R6
endmodule

// File: rtl/lsr_snapshot_shifter.sv
module lsr_snapshot_shifter
    import lsr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cap_en,
    input  logic [WIDTH-1:0] par_in,
    input  logic             shift_en,
    input  logic             load_mode,
    input  logic             ser_in,
    input  logic             oe_n,
    output logic             ser_out,
    output logic             ser_out_en
);
    localparam int TOP = WIDTH - 1;

    logic [WIDTH-1:0] held;
    logic [WIDTH-1:0] chain;
    op_e              op;

    assign op = op_e'(load_mode);

    lsr_hold_reg #(.WIDTH(WIDTH)) u_hold (
        .clk    (clk),
        .rst    (rst),
        .cap_en (cap_en),
        .par_in (par_in),
        .held   (held)
    );

    lsr_shift_chain #(.WIDTH(WIDTH)) u_chain (
        .clk      (clk),
        .rst      (rst),
        .shift_en (shift_en),
        .op       (op),
        .ser_in   (ser_in),
        .load_val (held),
        .chain    (chain)
    );

    lsr_out_stage u_out (
        .clk        (clk),
        .rst        (rst),
        .tail       (chain[TOP]),
        .oe_n       (oe_n),
        .ser_out    (ser_out),
        .ser_out_en (ser_out_en)
    );

    AST_SAME_EDGE_OLD: assert property (@(posedge clk) disable iff (rst)
        (cap_en && shift_en && op == OP_LOAD) |=> chain == $past(held)); // R7
    AST_CAPTURE_NO_DISTURB: assert property (@(posedge clk) disable iff (rst)
        (cap_en && !shift_en) |=> $stable(chain)); // R8
endmodule

// File: tb/lsr_snapshot_shifter_test.sv
module lsr_snapshot_shifter_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cap_en = 1'b0;
    logic [7:0] par_in = 8'h00;
    logic       shift_en = 1'b0;
    logic       load_mode = 1'b0;
    logic       ser_in = 1'b0;
    logic       oe_n = 1'b0;
    logic       ser_out;
    logic       ser_out_en;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    lsr_snapshot_shifter uut (
        .clk(clk), .rst(rst), .cap_en(cap_en), .par_in(par_in),
        .shift_en(shift_en), .load_mode(load_mode), .ser_in(ser_in),
        .oe_n(oe_n), .ser_out(ser_out), .ser_out_en(ser_out_en)
    );

    task automatic check(input logic act, input logic exp, input string req);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic capture(input logic [7:0] b);
        cap_en = 1'b1; par_in = b; tick(); cap_en = 1'b0;
    endtask

    task automatic load();
        shift_en = 1'b1; load_mode = 1'b1; tick(); shift_en = 1'b0; load_mode = 1'b0;
    endtask

    task automatic shift(input logic b);
        shift_en = 1'b1; load_mode = 1'b0; ser_in = b; tick(); shift_en = 1'b0; ser_in = 1'b0;
    endtask

    // read 8 bits MSB first, shifting in zeros
    task automatic drain(input logic [7:0] exp, input string req);
        for (int i = 7; i >= 0; i--) begin
            check(ser_out, exp[i], req);
            shift(1'b0);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1; tick(); tick(); rst = 1'b0;
        check(ser_out_en, 1'b1, "R1");
        drain(8'h00, "R1");
        load();
        check(ser_out, 1'b0, "R1");
        drain(8'h00, "R1");
    endtask

    task automatic t_load_order();
        capture(8'hA5);
        load();
        check(ser_out, 1'b1, "R3");
        drain(8'hA5, "R9");
        capture(8'h6C);
        load();
        drain(8'h6C, "R2");
    endtask

    task automatic t_serial();
        logic [7:0] pat = 8'b1101_0010;
        for (int i = 7; i >= 0; i--) shift(pat[i]);
        drain(pat, "R4");
    endtask

    task automatic t_hold();
        capture(8'h81);
        load();
        par_in = 8'h7E;
        for (int i = 0; i < 4; i++) begin
            tick();
            check(ser_out, 1'b1, "R5");
        end
        load();
        drain(8'h81, "R2");
    endtask

    task automatic t_oe();
        capture(8'h80);
        load();
        oe_n = 1'b1; #1;
        check(ser_out_en, 1'b0, "R6");
        check(ser_out, 1'b0, "R6");
        oe_n = 1'b0; #1;
        check(ser_out_en, 1'b1, "R6");
        check(ser_out, 1'b1, "R6");
        drain(8'h80, "R6");
    endtask

    task automatic t_same_edge();
        capture(8'h3C);
        cap_en = 1'b1; par_in = 8'hC3;
        shift_en = 1'b1; load_mode = 1'b1;
        tick();
        cap_en = 1'b0; shift_en = 1'b0; load_mode = 1'b0;
        drain(8'h3C, "R7");
        load();
        drain(8'hC3, "R7");
    endtask

    task automatic t_snapshot();
        capture(8'hF0);
        load();
        for (int i = 7; i >= 4; i--) begin
            check(ser_out, 1'b1, "R8");
            shift(1'b0);
        end
        capture(8'h0F);
        for (int i = 3; i >= 0; i--) begin
            check(ser_out, 1'b0, "R8");
            shift(1'b0);
        end
        load();
        drain(8'h0F, "R8");
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        tick();
        t_reset();
        t_load_order();
        t_serial();
        t_hold();
        t_oe();
        t_same_edge();
        t_snapshot();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule